// File: doc/BRIEF.md
# Event Timer Block Front End: Main Counter and Register Decoder

This block is the register-facing front end of a multi-channel event timer. It owns a 64-bit free-running main counter, a read-only capability word pair, and a two-bit global control register. It decodes a 1 KB register window into global registers and per-channel register blocks. The per-channel comparator and interrupt logic sit outside and talk to this block through plain strobes and a combinational read-back path.

Register traffic enters on a valid/ready request channel and leaves on a valid/ready response channel. Only reads produce a response. A request is accepted when `acc_valid` and `acc_ready` are both high. `acc_ready` is low only while a response is held and `rsp_ready` is low, so at most one read is pending. A held response keeps its data unchanged until it is taken. The counter advances by one per clock while the global enable is set and holds its value otherwise. An enable rising edge sends an arm strobe to every channel whose comparator does not hold the all-ones value. An enable falling edge sends one disarm pulse to all channels.

Top module: `tmr_front`

## Requirements
- R1: Only accesses with `acc_size` = 2 (4 bytes) and `acc_addr[1:0]` = 0 take effect. Any other access leaves all state unchanged and, for a read, returns zero.
- R2: Offset 0x000 reads {VENDOR_ID[15:0], bit15 = 1 (legacy-route capable), bit14 = 0, bit13 = 1 (64-bit counter), bits12:8 = NUM_TIMERS-1, bits7:0 = 0x01}. Offset 0x004 reads TICK_FS. Writes to either offset are ignored.
- R3: Offset 0x010 holds enable in bit 0 and legacy routing in bit 1. Every other bit reads 0 and is not writable. `legacy_mode` follows bit 1. Offset 0x014 reads 0 and ignores writes.
- R4: While enabled, the counter increases by exactly one on every clock. While disabled, it holds its value. Offsets 0x0F0 and 0x0F4 read its low and high halves.
- R5: A write to 0x0F0 replaces only the low 32 bits of the counter, and a write to 0x0F4 replaces only the high 32 bits. A counter write takes precedence over the increment in its cycle.
- R6: A config write that takes enable from 0 to 1 drives `ch_arm` high for one cycle, in the cycle after the write. Bit i is set exactly when `ch_cmp_max[i]` is 0. A write that leaves enable at 1 raises no arm.
- R7: A config write that takes enable from 1 to 0 drives `ch_disarm` high for one cycle, in the cycle after the write.
- R8: Offsets 0x100 and up form channel blocks with a 0x20 stride. Channel index = (addr-0x100)>>5 and word = addr[4:2], in the order config, config-high, comparator, comparator-high, route, route-high. A read of word 0, 2, 3, 4 or 5 returns that channel's `ch_rdata` slice while `ch_rd_word` carries the word. A write to one of those words sets `ch_wr[index]` for one cycle after the write, with `ch_wr_word` and `ch_wr_data`.
- R9: Word 1 of a channel block reads ROUTE_CAP (default 0x4, route 2 available), and writes to it are not forwarded. Words 6 and 7 read 0 and are not forwarded.
- R10: A channel index of NUM_TIMERS or more reads 0 and raises no `ch_wr`.
- R11: Offset 0x020 reads `ch_status` zero-extended. A write to it pulses `ch_clr` = wdata & `ch_status` for one cycle after the write.
- R12: Global offsets not listed above read 0.
- R13: `acc_ready` is low exactly while `rsp_valid` is high and `rsp_ready` is low. `rsp_data` and `rsp_valid` hold while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request valid |
| acc_ready | output | 1 | Request accepted when high with valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset in the window |
| acc_size | input | 2 | log2 of access bytes |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | 32 | Read data |
| ch_rd_word | output | 3 | Word index of the current request, for channel read-back |
| ch_rdata | input | NUM_TIMERS*32 | Channel read data, channel i at bits [32i+31:32i] |
| ch_status | input | NUM_TIMERS | Channel interrupt status |
| ch_cmp_max | input | NUM_TIMERS | Channel comparator is all ones |
| ch_wr | output | NUM_TIMERS | Channel write strobe |
| ch_wr_word | output | 3 | Word index of the write |
| ch_wr_data | output | 32 | Write data to channel |
| ch_clr | output | NUM_TIMERS | Status clear strobe |
| ch_arm | output | NUM_TIMERS | Arm strobe on enable rise |
| ch_disarm | output | 1 | Disarm-all pulse on enable fall |
| legacy_mode | output | 1 | Legacy routing selected |

## Verification
The hardest case to reach is an exact count of counter ticks across an enable window. Nothing shows the counter while it runs, so its value can only be read after it is frozen again. The stimulus enables the block, waits a known number of idle clocks, and disables it. It then expects the frozen value to be the seeded value plus the number of clocks from the enable write to the disable write. The stall case uses the same kind of sequence: `rsp_ready` is held low while a second request waits, which shows that the held data does not move and that the waiting request is not taken.

// File: rtl/tmr_front_pkg.sv
package tmr_front_pkg;
  localparam int CNT_W      = 64;
  localparam int DATA_W     = 32;
  localparam int BLK_BASE   = 256;
  localparam int BLK_SHIFT  = 5;
  localparam logic [2:0] WD_CFG_HI = 3'd1;
  localparam logic [2:0] WD_LAST   = 3'd5;

  localparam logic [7:0] OFS_CAP_LO = 8'h00;
  localparam logic [7:0] OFS_CAP_HI = 8'h04;
  localparam logic [7:0] OFS_CFG    = 8'h10;
  localparam logic [7:0] OFS_CFG_HI = 8'h14;
  localparam logic [7:0] OFS_STAT   = 8'h20;
  localparam logic [7:0] OFS_CNT_LO = 8'hF0;
  localparam logic [7:0] OFS_CNT_HI = 8'hF4;

  typedef enum logic [3:0] {
    RG_NONE, RG_CAP_LO, RG_CAP_HI, RG_CFG, RG_CFG_HI,
    RG_STAT, RG_CNT_LO, RG_CNT_HI, RG_BLK
  } region_e;
endpackage

// File: rtl/tmr_front_decode.sv
module tmr_front_decode
  import tmr_front_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int NUM_TIMERS = 3,
  localparam int TIX_W     = ADDR_W - BLK_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output region_e           region,
  output logic [TIX_W-1:0]  tidx,
  output logic [2:0]        word
);
  localparam logic [TIX_W-1:0] BLK_IDX0 = TIX_W'(BLK_BASE >> BLK_SHIFT);

  always_comb begin
    tidx   = addr[ADDR_W-1:BLK_SHIFT] - BLK_IDX0;
    word   = addr[4:2];
    region = RG_NONE;
    if (size == 2'd2 && addr[1:0] == 2'b00) begin
      if (addr >= ADDR_W'(BLK_BASE)) begin
        if (32'(tidx) < NUM_TIMERS) region = RG_BLK;
      end else begin
        case (addr[7:0])
          OFS_CAP_LO: region = RG_CAP_LO;
          OFS_CAP_HI: region = RG_CAP_HI;
          OFS_CFG:    region = RG_CFG;
          OFS_CFG_HI: region = RG_CFG_HI;
          OFS_STAT:   region = RG_STAT;
          OFS_CNT_LO: region = RG_CNT_LO;
          OFS_CNT_HI: region = RG_CNT_HI;
          default:    region = RG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_front_counter.sv
module tmr_front_counter
  import tmr_front_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cnt_wr_lo,
  input  logic                  cnt_wr_hi,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_TIMERS-1:0] cmp_max,
  output logic                  en_q,
  output logic                  leg_q,
  output logic [CNT_W-1:0]      cnt_q,
  output logic [NUM_TIMERS-1:0] arm,
  output logic                  disarm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      leg_q  <= 1'b0;
      cnt_q  <= '0;
      arm    <= '0;
      disarm <= 1'b0;
    end else begin
      arm    <= '0;
      disarm <= 1'b0;
      if (cfg_wr) begin
        en_q  <= wdata[0];
        leg_q <= wdata[1];
        if (!en_q && wdata[0]) arm <= ~cmp_max;
        if (en_q && !wdata[0]) disarm <= 1'b1;
      end
      if (cnt_wr_lo)      cnt_q[DATA_W-1:0]     <= wdata;
      else if (cnt_wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
      else if (en_q)      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_front_rdmux.sv
module tmr_front_rdmux
  import tmr_front_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          TIX_W      = 5,
  parameter logic [15:0] VENDOR_ID  = 16'hCAFE,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  parameter logic [31:0] ROUTE_CAP  = 32'h0000_0004
) (
  input  region_e                      region,
  input  logic [TIX_W-1:0]             tidx,
  input  logic [2:0]                   word,
  input  logic                         en,
  input  logic                         leg,
  input  logic [NUM_TIMERS-1:0]        status,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_TIMERS*DATA_W-1:0] ch_rdata,
  output logic [DATA_W-1:0]            rd_word
);
  localparam logic [DATA_W-1:0] CAP_LO =
    {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NUM_TIMERS - 1), 8'h01};

  logic [DATA_W-1:0] blk_data;

  always_comb begin
    blk_data = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (tidx == TIX_W'(i)) blk_data = ch_rdata[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (region)
      RG_CAP_LO: rd_word = CAP_LO;
      RG_CAP_HI: rd_word = TICK_FS;
      RG_CFG:    rd_word = {30'd0, leg, en};
      RG_STAT:   rd_word = DATA_W'(status);
      RG_CNT_LO: rd_word = cnt[DATA_W-1:0];
      RG_CNT_HI: rd_word = cnt[CNT_W-1:DATA_W];
      RG_BLK: begin
        if (word == WD_CFG_HI)    rd_word = ROUTE_CAP;
        else if (word <= WD_LAST) rd_word = blk_data;
        else                      rd_word = '0;
      end
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/tmr_front.sv
module tmr_front
  import tmr_front_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int          NUM_TIMERS = 3,
  parameter logic [15:0] VENDOR_ID  = 16'hCAFE,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  parameter logic [31:0] ROUTE_CAP  = 32'h0000_0004
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_valid,
  output logic                         acc_ready,
  input  logic                         acc_write,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic [1:0]                   acc_size,
  input  logic [31:0]                  acc_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [31:0]                  rsp_data,
  output logic [2:0]                   ch_rd_word,
  input  logic [NUM_TIMERS*32-1:0]     ch_rdata,
  input  logic [NUM_TIMERS-1:0]        ch_status,
  input  logic [NUM_TIMERS-1:0]        ch_cmp_max,
  output logic [NUM_TIMERS-1:0]        ch_wr,
  output logic [2:0]                   ch_wr_word,
  output logic [31:0]                  ch_wr_data,
  output logic [NUM_TIMERS-1:0]        ch_clr,
  output logic [NUM_TIMERS-1:0]        ch_arm,
  output logic                         ch_disarm,
  output logic                         legacy_mode
);
  localparam int TIX_W = ADDR_W - BLK_SHIFT;

  region_e           region;
  logic [TIX_W-1:0]  tidx;
  logic [2:0]        word;
  logic [31:0]       rd_word;
  logic              glb_en;
  logic [CNT_W-1:0]  cnt_q;
  logic              acc_fire, wr_fire, rd_fire;
  logic              cnt_wr_lo, cnt_wr_hi, cnt_wr_any;
  logic [NUM_TIMERS-1:0] blk_sel;

  assign acc_ready  = !rsp_valid || rsp_ready;
  assign acc_fire   = acc_valid && acc_ready;
  assign wr_fire    = acc_fire && acc_write;
  assign rd_fire    = acc_fire && !acc_write;
  assign cnt_wr_lo  = wr_fire && region == RG_CNT_LO;
  assign cnt_wr_hi  = wr_fire && region == RG_CNT_HI;
  assign cnt_wr_any = cnt_wr_lo || cnt_wr_hi;
  assign ch_rd_word = word;

  tmr_front_decode #(.ADDR_W(ADDR_W), .NUM_TIMERS(NUM_TIMERS)) u_dec (
    .addr(acc_addr), .size(acc_size), .region(region), .tidx(tidx), .word(word)
  );

  tmr_front_counter #(.NUM_TIMERS(NUM_TIMERS)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(wr_fire && region == RG_CFG),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
    .wdata(acc_wdata), .cmp_max(ch_cmp_max),
    .en_q(glb_en), .leg_q(legacy_mode), .cnt_q(cnt_q),
    .arm(ch_arm), .disarm(ch_disarm)
  );

  tmr_front_rdmux #(
    .NUM_TIMERS(NUM_TIMERS), .TIX_W(TIX_W), .VENDOR_ID(VENDOR_ID),
    .TICK_FS(TICK_FS), .ROUTE_CAP(ROUTE_CAP)
  ) u_rd (
    .region(region), .tidx(tidx), .word(word), .en(glb_en), .leg(legacy_mode),
    .status(ch_status), .cnt(cnt_q), .ch_rdata(ch_rdata), .rd_word(rd_word)
  );

  generate
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_sel
      assign blk_sel[g] = (region == RG_BLK) && (tidx == TIX_W'(g))
                          && (word != WD_CFG_HI) && (word <= WD_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_wr      <= '0;
      ch_clr     <= '0;
      ch_wr_word <= '0;
      ch_wr_data <= '0;
    end else begin
      ch_wr  <= wr_fire ? blk_sel : '0;
      ch_clr <= (wr_fire && region == RG_STAT) ?
                (acc_wdata[NUM_TIMERS-1:0] & ch_status) : '0;
      if (wr_fire) begin
        ch_wr_word <= word;
        ch_wr_data <= acc_wdata;
      end
    end
  end
endmodule

// File: rtl/tmr_front_checker.sv
module tmr_front_checker #(
  parameter int NUM_TIMERS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [63:0]           cnt,
  input logic                  cnt_wr,
  input logic [NUM_TIMERS-1:0] ch_arm,
  input logic                  ch_disarm,
  input logic [NUM_TIMERS-1:0] ch_wr,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [31:0]           rsp_data
);
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt));
  a_r4_step_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_wr) |=> cnt == $past(cnt) + 64'd1);
  a_r6_arm_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_arm) |=> ch_arm == '0);
  a_r6_arm_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_arm) |-> en);
  a_r7_disarm_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ch_disarm |-> !en);
  a_r8_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr));
  a_r13_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind tmr_front tmr_front_checker #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(glb_en), .cnt(cnt_q), .cnt_wr(cnt_wr_any),
  .ch_arm(ch_arm), .ch_disarm(ch_disarm), .ch_wr(ch_wr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/tmr_front_bench.sv
module tmr_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;
  localparam int IDLE = 9;
  localparam logic [31:0] EXP_CAP = 32'hCAFE_A201;
  localparam logic [31:0] EXP_PER = 32'd10_000_000;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, rsp_ready = 1;
  logic [9:0] acc_addr = '0;
  logic [1:0] acc_size = 2'd2;
  logic [31:0] acc_wdata = '0;
  logic acc_ready, rsp_valid, ch_disarm, legacy_mode;
  logic [31:0] rsp_data, ch_wr_data;
  logic [2:0] ch_rd_word, ch_wr_word;
  logic [NT*32-1:0] ch_rdata;
  logic [NT-1:0] ch_status = 3'b101, ch_cmp_max = 3'b010;
  logic [NT-1:0] ch_wr, ch_clr, ch_arm;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NT; i++)
      ch_rdata[i*32 +: 32] = 32'hC000_0000 | (32'(i) << 8) | 32'(ch_rd_word);
  end

  tmr_front u_tmr_front (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .ch_rd_word(ch_rd_word), .ch_rdata(ch_rdata),
    .ch_status(ch_status), .ch_cmp_max(ch_cmp_max), .ch_wr(ch_wr),
    .ch_wr_word(ch_wr_word), .ch_wr_data(ch_wr_data), .ch_clr(ch_clr),
    .ch_arm(ch_arm), .ch_disarm(ch_disarm), .legacy_mode(legacy_mode)
  );

  // {tag, write, addr, wdata, expected read}
  localparam int NV = 19;
  localparam logic [78:0] VEC [NV] = '{
    {4'd2,  1'b0, 10'h000, 32'h0,        EXP_CAP},      // R2
    {4'd2,  1'b0, 10'h004, 32'h0,        EXP_PER},      // R2
    {4'd2,  1'b1, 10'h000, 32'hFFFF_FFFF, 32'h0},       // R2 write ignored
    {4'd2,  1'b0, 10'h000, 32'h0,        EXP_CAP},      // R2
    {4'd3,  1'b1, 10'h014, 32'hFFFF_FFFF, 32'h0},       // R3
    {4'd3,  1'b0, 10'h014, 32'h0,        32'h0},        // R3
    {4'd3,  1'b1, 10'h010, 32'hFFFF_FFFC, 32'h0},       // R3
    {4'd3,  1'b0, 10'h010, 32'h0,        32'h0},        // R3
    {4'd5,  1'b1, 10'h0F0, 32'h1234_5678, 32'h0},       // R5
    {4'd5,  1'b1, 10'h0F4, 32'h9ABC_DEF0, 32'h0},       // R5
    {4'd5,  1'b0, 10'h0F0, 32'h0,        32'h1234_5678}, // R5
    {4'd5,  1'b0, 10'h0F4, 32'h0,        32'h9ABC_DEF0}, // R5
    {4'd12, 1'b0, 10'h0A0, 32'h0,        32'h0},        // R12
    {4'd9,  1'b0, 10'h124, 32'h0,        32'h0000_0004}, // R9
    {4'd9,  1'b0, 10'h118, 32'h0,        32'h0},        // R9
    {4'd8,  1'b0, 10'h148, 32'h0,        32'hC000_0202}, // R8
    {4'd8,  1'b0, 10'h110, 32'h0,        32'hC000_0004}, // R8
    {4'd10, 1'b0, 10'h160, 32'h0,        32'h0},        // R10
    {4'd11, 1'b0, 10'h020, 32'h0,        32'h0000_0005}  // R11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d; acc_size = sz;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_size = 2'd2;
  endtask

  task automatic do_rd(input logic [9:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = sz;
    @(posedge clk);
    @(negedge clk);
    d = rsp_data;
    acc_valid = 0; acc_size = 2'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, lo0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R13 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R13 reset acc_ready", 64'(acc_ready), 64'd1);
    check("R6 reset arm", 64'(ch_arm), 64'd0);
    check("R3 reset legacy", 64'(legacy_mode), 64'd0);
    do_rd(10'h0F0, rd);
    check("R4 reset counter", 64'(rd), 64'd0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][74]) do_wr(VEC[v][73:64], VEC[v][63:32]);
      else begin
        do_rd(VEC[v][73:64], rd);
        check($sformatf("R%0d vector %0d", VEC[v][78:75], v), 64'(rd), 64'(VEC[v][31:0]));
      end
    end

    // R1: non-word accesses
    do_wr(10'h0F0, 32'hFFFF_FFFF, 2'd1);
    do_rd(10'h0F0, rd);
    check("R1 narrow write ignored", 64'(rd), 64'h1234_5678);
    do_rd(10'h0F0, rd, 2'd1);
    check("R1 narrow read zero", 64'(rd), 64'd0);
    do_rd(10'h0F2, rd);
    check("R1 misaligned read zero", 64'(rd), 64'd0);

    // R6 / R4 / R7: enable window
    do_wr(10'h010, 32'h3);
    check("R6 arm mask", 64'(ch_arm), 64'b101);
    check("R3 legacy on", 64'(legacy_mode), 64'd1);
    do_rd(10'h010, rd);
    check("R3 config readback", 64'(rd), 64'd3);
    check("R6 arm one cycle", 64'(ch_arm), 64'd0);
    do_wr(10'h010, 32'h1);
    check("R6 no re-arm while enabled", 64'(ch_arm), 64'd0);
    repeat (IDLE) @(negedge clk);
    do_wr(10'h010, 32'h0);
    check("R7 disarm pulse", 64'(ch_disarm), 64'd1);
    do_rd(10'h0F0, rd);
    check("R7 disarm one cycle", 64'(ch_disarm), 64'd0);
    // enable accepted, then 1 read + 1 write + IDLE + disable: 3 + IDLE edges
    lo0 = 32'h1234_5678 + 32'(IDLE + 3);
    check("R4 counted ticks", 64'(rd), 64'(lo0));
    repeat (5) @(negedge clk);
    do_rd(10'h0F0, rd);
    check("R4 frozen", 64'(rd), 64'(lo0));
    do_rd(10'h0F4, rd);
    check("R5 high half untouched", 64'(rd), 64'h9ABC_DEF0);

    // R8 / R9 / R10: channel writes
    do_wr(10'h12C, 32'h55);
    check("R8 write strobe", 64'(ch_wr), 64'b010);
    check("R8 write word", 64'(ch_wr_word), 64'd3);
    check("R8 write data", 64'(ch_wr_data), 64'h55);
    do_wr(10'h104, 32'h1);
    check("R9 cfg-high not forwarded", 64'(ch_wr), 64'd0);
    do_wr(10'h1A0, 32'h1);
    check("R10 out of range no strobe", 64'(ch_wr), 64'd0);

    // R11: status clear
    do_wr(10'h020, 32'h7);
    check("R11 clear masked", 64'(ch_clr), 64'b101);
    do_wr(10'h020, 32'h2);
    check("R11 clear of unset bit", 64'(ch_clr), 64'd0);

    // R13: stalled response
    rsp_ready = 0;
    do_rd(10'h004, rd);
    acc_valid = 1; acc_write = 0; acc_addr = 10'h000;
    #1;
    check("R13 ready low when stalled", 64'(acc_ready), 64'd0);
    repeat (2) @(negedge clk);
    check("R13 held valid", 64'(rsp_valid), 64'd1);
    check("R13 held data", 64'(rsp_data), 64'(EXP_PER));
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    check("R13 next read after release", 64'(rsp_data), 64'(EXP_CAP));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule